// File: doc/BRIEF.md
# Real-Time-Clock Register Bank

This block is the storage side of a real-time-clock slave on a two-wire serial bus. Upstream bus logic decodes bits into bytes and hands this block a start pulse carrying the 7-bit device address, a strobe that loads the register pointer, byte-write strobes and byte-read requests. The block answers only to its own device address. It keeps a 64-byte space, with the pointer stepping by one after each byte moved. The space holds seven BCD timekeeping bytes, a control byte and 56 bytes of general-purpose RAM.

Fields that are reserved are cleared as they are written, so they always read back as zero. The clock-halt flag in the seconds byte gates the external one-second tick and holds the square-wave divider at zero. The control byte drives an output pin. That pin carries either a static level or one tap of a 15-bit divider that counts a 32768 Hz reference enable. Advancing the time and the bit-level bus protocol belong to neighbouring logic.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the byte at address 0 reads 0x80, so the clock is halted. Every other byte reads 0x00, the pointer is 0, the device is unselected, and sqw_o and rvalid_o are 0.
- R2: A start pulse with dev_addr_i equal to 0x68 selects the device. A start pulse with any other address deselects it. While the device is unselected, pointer loads, writes and reads have no effect, and rvalid_o stays 0.
- R3: A read request while the device is selected gives rvalid_o=1 on the next cycle. rdata_o then holds the byte at the pointer, and the pointer advances by one.
- R4: A write while the device is selected stores the byte at the pointer and advances the pointer by one. When a write and a read come in the same cycle, the write is done and the read is dropped.
- R5: The pointer wraps from 63 to 0 after a byte is moved at address 63.
- R6: ptr_load_i, while the device is selected, loads the pointer from ptr_i. A load takes priority over a write or read in the same cycle.
- R7: Reserved bits are stored as zero. These are bit 7 at addresses 1 and 2, bits 7:3 at 3, bits 7:6 at 4, bits 7:5 at 5, and bits 6, 5, 3 and 2 at address 7. Addresses 0 and 6 keep all 8 bits, and so does RAM at 8 to 63.
- R8: tick_o follows tick_i when bit 7 of address 0 (the clock-halt flag) is 0, and it is 0 when that bit is 1.
- R9: When bit 4 of address 7 (the square-wave enable) is 0, sqw_o equals bit 7 of address 7.
- R10: When the square-wave enable is 1, sqw_o is one bit of a divider that counts ref_en_i pulses from zero. Rate code bits 1:0 select the bit: 00 picks bit 14, 01 picks bit 2, 10 picks bit 1 and 11 picks bit 0.
- R11: While the clock-halt flag is 1, the divider is held at zero. In square-wave mode, sqw_o is therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transaction start pulse |
| dev_addr_i | input | 7 | Device address that comes with start_i |
| ptr_load_i | input | 1 | Pointer load strobe |
| ptr_i | input | 6 | New pointer value |
| wr_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Write byte |
| rd_i | input | 1 | Byte read request |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | rdata_o valid, one cycle after rd_i |
| tick_i | input | 1 | One-second tick from the time-keeping logic |
| tick_o | output | 1 | Tick gated by the clock-halt flag |
| ref_en_i | input | 1 | 32768 Hz reference enable |
| sqw_o | output | 1 | Square-wave or static output pin |

## Verification
A pointer that is off by one, or that fails to wrap, shows up on the very next read as a byte from the wrong address, one cycle after the request. A mask that is wrong shows up as a nonzero reserved bit on the first read after a write of 0xFF. A divider that is not cleared by the halt flag, or a rate decode that picks the wrong bit, shows up on sqw_o within a few reference pulses for the fast codes. For the 1 Hz code it shows up only after 16384 pulses, so the bench counts that many. A wrong address compare shows up as writes to the wrong device landing, or as rvalid_o pulsing.

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 6,
  parameter int         DIV_W    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [6:0]    dev_addr_i,
  input  logic          ptr_load_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          rd_i,
  output logic [7:0]    rdata_o,
  output logic          rvalid_o,
  input  logic          tick_i,
  output logic          tick_o,
  input  logic          ref_en_i,
  output logic          sqw_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    ptr;
  logic             sel;
  logic [DIV_W-1:0] div;
  logic             tap;

  wire       ch    = mem[0][7];
  wire [7:0] ctrl  = mem[7];
  wire       do_wr = sel & wr_i & ~ptr_load_i;
  wire       do_rd = sel & rd_i & ~wr_i & ~ptr_load_i;

  function automatic logic [7:0] keep_bits(input logic [AW-1:0] a);
    case (a)
      AW'(1), AW'(2): keep_bits = 8'h7F;
      AW'(3):         keep_bits = 8'h07;
      AW'(4):         keep_bits = 8'h3F;
      AW'(5):         keep_bits = 8'h1F;
      AW'(7):         keep_bits = 8'h93;
      default:        keep_bits = 8'hFF;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == 0) ? 8'h80 : 8'h00;
    end else if (do_wr) begin
      mem[ptr] <= wdata_i & keep_bits(ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      ptr      <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= 8'h00;
    end else begin
      if (start_i) sel <= (dev_addr_i == DEV_ADDR);
      if (sel && ptr_load_i) ptr <= ptr_i;
      else if (do_wr || do_rd) ptr <= ptr + 1'b1;
      rvalid_o <= do_rd;
      if (do_rd) rdata_o <= mem[ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ch) div <= '0;
    else if (ref_en_i) div <= div + 1'b1;
  end

  always_comb begin
    case (ctrl[1:0])
      2'b00:   tap = div[DIV_W-1];
      2'b01:   tap = div[2];
      2'b10:   tap = div[1];
      default: tap = div[0];
    endcase
  end

  assign sqw_o  = ctrl[4] ? tap : ctrl[7];
  assign tick_o = tick_i & ~ch;
endmodule

module rtc_regbank_chk #(
  parameter int AW    = 6,
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ptr_load_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic             rvalid_o,
  input logic             sel,
  input logic [AW-1:0]    ptr,
  input logic [DIV_W-1:0] div,
  input logic             ch,
  input logic [7:0]       ctrl
);
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sel && rd_i && !wr_i && !ptr_load_i |=> rvalid_o); // R3
  AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rvalid_o); // R2
  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ptr)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sel && (wr_i || rd_i) && !ptr_load_i |=> ptr == AW'($past(ptr) + 1'b1)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sel && (wr_i || rd_i) && !ptr_load_i && (ptr == '1) |=> ptr == '0); // R5
  AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl & 8'h6C) == 8'h00); // R7
  AST_DIV_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    ch |=> div == '0); // R11
endmodule

bind rtc_regbank rtc_regbank_chk #(.AW(AW), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ptr_load_i(ptr_load_i),
  .wr_i(wr_i), .rd_i(rd_i), .rvalid_o(rvalid_o), .sel(sel), .ptr(ptr),
  .div(div), .ch(ch), .ctrl(ctrl)
);

// File: tb/rtc_regbank_bench.sv
module rtc_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic       ptr_load_i = 1'b0;
  logic [5:0] ptr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  logic       tick_i = 1'b0;
  logic       tick_o;
  logic       ref_en_i = 1'b0;
  logic       sqw_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rtc_regbank u_rtc_regbank (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .ptr_load_i(ptr_load_i), .ptr_i(ptr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .tick_i(tick_i),
    .tick_o(tick_o), .ref_en_i(ref_en_i), .sqw_o(sqw_o)
  );

  // {address, written byte, expected readback}
  localparam logic [23:0] VEC [11] = '{
    {8'd1,  8'hFF, 8'h7F}, {8'd2,  8'hFF, 8'h7F}, {8'd3,  8'hFF, 8'h07},
    {8'd4,  8'hFF, 8'h3F}, {8'd5,  8'hFF, 8'h1F}, {8'd6,  8'hFF, 8'hFF},
    {8'd7,  8'hFF, 8'h93}, {8'd0,  8'h59, 8'h59}, {8'd0,  8'hFF, 8'hFF},
    {8'd32, 8'hA5, 8'hA5}, {8'd63, 8'h5A, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic select(input logic [6:0] a);
    start_i = 1'b1; dev_addr_i = a;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic load(input logic [5:0] p);
    ptr_load_i = 1'b1; ptr_i = p;
    @(negedge clk); ptr_load_i = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic get(input string req, input logic [7:0] exp);
    rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    chk(req, {23'd0, rvalid_o, rdata_o}, {23'd0, 1'b1, exp});
  endtask

  task automatic pulses(input int n);
    ref_en_i = 1'b1;
    repeat (n) @(negedge clk);
    ref_en_i = 1'b0;
  endtask

  task automatic sq_setup(input logic [7:0] c);
    load(6'd0); put(8'h80);
    @(negedge clk);
    load(6'd7); put(c);
    load(6'd0); put(8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 sqw", {31'd0, sqw_o}, 32'd0);
    chk("R1 rvalid", {31'd0, rvalid_o}, 32'd0);
    tick_i = 1'b1; #1;
    chk("R8 halted tick", {31'd0, tick_o}, 32'd0);
    tick_i = 1'b0;
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    chk("R1 unselected read", {31'd0, rvalid_o}, 32'd0);
    select(7'h68);
    get("R1 seconds", 8'h80);
    get("R1 minutes", 8'h00);

    // R7 / R3 / R4: table walk
    for (int i = 0; i < 11; i++) begin
      load(VEC[i][21:16]); put(VEC[i][15:8]);
      load(VEC[i][21:16]); get("R7 mask", VEC[i][7:0]);
    end

    // R4: auto-increment over a burst
    load(6'd8); put(8'h11); put(8'h22); put(8'h33);
    load(6'd8);
    get("R4 burst0", 8'h11); get("R4 burst1", 8'h22); get("R4 burst2", 8'h33);

    // R5: wrap from 63 to 0
    load(6'd63); put(8'hC3);
    get("R5 wrap to 0", 8'hFF);
    load(6'd63); get("R5 at 63", 8'hC3);
    get("R5 read wrap", 8'hFF);

    // R4: write wins over read in the same cycle
    load(6'd9);
    wr_i = 1'b1; rd_i = 1'b1; wdata_i = 8'h77;
    @(negedge clk); wr_i = 1'b0; rd_i = 1'b0;
    chk("R4 read dropped", {31'd0, rvalid_o}, 32'd0);
    get("R4 next addr", 8'h33);
    load(6'd9); get("R4 written", 8'h77);

    // R6: load beats write
    load(6'd12);
    ptr_load_i = 1'b1; ptr_i = 6'd20; wr_i = 1'b1; wdata_i = 8'hEE;
    @(negedge clk); ptr_load_i = 1'b0; wr_i = 1'b0;
    get("R6 load priority", 8'h00);
    load(6'd12); get("R6 no write", 8'h00);

    // R2: foreign address ignored
    load(6'd40);
    select(7'h50);
    load(6'd41); put(8'h99);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    chk("R2 no rvalid", {31'd0, rvalid_o}, 32'd0);
    select(7'h68);
    get("R2 pointer kept, no write", 8'h00);
    get("R2 addr 41 untouched", 8'h00);

    // R8: tick passes when running
    load(6'd0); put(8'h00);
    tick_i = 1'b1; #1;
    chk("R8 running tick", {31'd0, tick_o}, 32'd1);
    tick_i = 1'b0;

    // R9: static level
    load(6'd7); put(8'h80);
    chk("R9 static high", {31'd0, sqw_o}, 32'd1);
    load(6'd7); put(8'h00);
    chk("R9 static low", {31'd0, sqw_o}, 32'd0);

    // R10: rate taps
    sq_setup(8'h11);
    pulses(3);  chk("R10 rate01 3", {31'd0, sqw_o}, 32'd0);
    pulses(1);  chk("R10 rate01 4", {31'd0, sqw_o}, 32'd1);
    sq_setup(8'h12);
    pulses(1);  chk("R10 rate10 1", {31'd0, sqw_o}, 32'd0);
    pulses(1);  chk("R10 rate10 2", {31'd0, sqw_o}, 32'd1);
    sq_setup(8'h13);
    pulses(1);  chk("R10 rate11 1", {31'd0, sqw_o}, 32'd1);
    sq_setup(8'h10);
    pulses(16383); chk("R10 rate00 16383", {31'd0, sqw_o}, 32'd0);
    pulses(1);     chk("R10 rate00 16384", {31'd0, sqw_o}, 32'd1);

    // R11: halt clears divider
    load(6'd0); put(8'h80);
    @(negedge clk);
    chk("R11 halted low", {31'd0, sqw_o}, 32'd0);
    pulses(5);
    chk("R11 held", {31'd0, sqw_o}, 32'd0);

    finish_run();
  end
endmodule